// File: doc/BRIEF.md
# Parallel-Product 16-Tap FIR Filter

This block is a 16-tap finite impulse response filter with fixed coefficients set by parameters. Each accepted signed sample is multiplied against all sixteen taps at once. The sixteen products are captured in their own registers. They are then reduced by a tree of carry-save (3:2) compressors and one final carry-propagate adder. The result comes out at full precision, so no rounding or saturation takes place.

A two-state controller sequences the work. In the waiting state it accepts a sample and loads the product registers. In the following summing state the sum of those products is presented at the output for one cycle with a valid strobe, and the tap delay line shifts by one position. Because of this, the filter accepts at most one sample every two cycles. It shows that through a ready output. The delay line moves only on accepted samples, so idle cycles do not advance the filter.

Top module: `fir16_par`

## Requirements
- R1: Synchronous active-high reset clears the delay line and the product registers, drops `out_valid` and returns the controller to waiting, so that `in_ready` is 1. Outputs after reset treat every earlier sample as zero.
- R2: `in_ready` is 1 exactly when the controller waits. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both 1.
- R3: `out_valid` is 1 for exactly one cycle, the cycle that directly follows the accepting edge, and at no other time.
- R4: While `out_valid` is 1, `out_data` equals the sum over k = 0..15 of coefficient k times the k-th most recent accepted sample. Here k = 0 is the sample just accepted, and coefficient k is bits [16k+15:16k] of `COEFS`.
- R5: A sample offered while `in_ready` is 0 is ignored. It produces no `out_valid` and does not appear in any later result.
- R6: Cycles without an accepted sample do not shift the delay line. A later result depends only on the sequence of accepted samples.
- R7: `out_data` is 2W+4 bits signed two's complement and is exact for all input and coefficient values, including sixteen products of −2^(W−1) × −2^(W−1).
- R8: Between results `out_data` holds the last result unchanged until the next sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | W | Signed input sample |
| in_ready | output | 1 | Controller is waiting and can accept a sample |
| out_valid | output | 1 | One-cycle strobe marking a fresh result |
| out_data | output | 2W+4 | Signed full-precision filter output |

## Verification
A sample offered on one rising edge produces its result in the very next cycle. The bench therefore drives inputs on falling edges and reads `out_valid` and `out_data` on the falling edge right after the accepting rising edge, where both must already be valid. One falling edge later, `out_valid` must be 0 and `in_ready` must be 1 again. Samples thrown at the block during that busy cycle are checked one cycle later for the absence of a strobe, and again later through the convolution of subsequent results. Idle stretches are checked cycle by cycle for a steady `out_data` and a low strobe.

// File: rtl/fir16_pkg.sv
package fir16_pkg;
  typedef enum logic { ST_WAIT = 1'b0, ST_SUM = 1'b1 } fir_state_t;
endpackage

// File: rtl/fir16_ctrl.sv
module fir16_ctrl
  import fir16_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic load_ev,
  output logic shift_ev
);
  fir_state_t state;

  assign in_ready = (state == ST_WAIT);
  assign load_ev  = in_valid && (state == ST_WAIT);
  assign shift_ev = (state == ST_SUM);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else if (state == ST_WAIT) state <= in_valid ? ST_SUM : ST_WAIT;
    else state <= ST_WAIT;
  end

  // R3: summing state lasts a single cycle
  a_r3_single_sum: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> !shift_ev);
  // R2: a load always leads into the summing state
  a_r2_load_then_sum: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> shift_ev);
endmodule

// File: rtl/fir16_taps.sv
module fir16_taps #(
  parameter int W    = 16,
  parameter int NTAP = 16,
  parameter int OW   = 2*W + 4,
  parameter logic [NTAP*W-1:0] COEFS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_ev,
  input  logic             shift_ev,
  input  logic [W-1:0]     in_sample,
  output logic [NTAP*OW-1:0] prod_flat
);
  logic [W-1:0]  rin;
  logic [W-1:0]  rs   [1:NTAP-1];
  logic [OW-1:0] prod [NTAP];

  function automatic logic [OW-1:0] sext(input logic [W-1:0] v);
    return {{(OW-W){v[W-1]}}, v};
  endfunction

  function automatic logic [OW-1:0] mul_ext(input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    return sext(a) * sext(b);
  endfunction

  function automatic logic [W-1:0] coef(input int k);
    return COEFS[k*W +: W];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rin <= '0;
      for (int k = 1; k < NTAP; k++) rs[k] <= '0;
    end else if (load_ev) begin
      rin <= in_sample;
    end else if (shift_ev) begin
      rs[1] <= rin;
      for (int k = 2; k < NTAP; k++) rs[k] <= rs[k-1];
    end
  end

  generate
    for (genvar k = 0; k < NTAP; k++) begin : g_prod
      always_ff @(posedge clk) begin
        if (rst) prod[k] <= '0;
        else if (load_ev) begin
          if (k == 0) prod[k] <= mul_ext(in_sample, coef(k));
          else        prod[k] <= mul_ext(rs[k], coef(k));
        end
      end
      assign prod_flat[k*OW +: OW] = prod[k];
    end
  endgenerate

  // R6: delay line holds when no shift occurs
  a_r6_line_holds: assert property (@(posedge clk) disable iff (rst)
    !shift_ev |=> $stable(rs[1]) && $stable(rs[NTAP-1]));
  // R8: products change only on a load
  a_r8_prod_hold: assert property (@(posedge clk) disable iff (rst)
    !load_ev |=> $stable(prod_flat));
endmodule

// File: rtl/fir16_csa_tree.sv
module fir16_csa_tree #(
  parameter int N  = 16,
  parameter int OW = 36
) (
  input  logic [N*OW-1:0] ops_flat,
  output logic [OW-1:0]   sum
);
  logic [OW-1:0] ops [N];
  logic [OW-1:0] nxt [N];
  int cnt;
  int ncnt;

  function automatic logic [OW-1:0] csa_s(input logic [OW-1:0] a, b, c);
    return a ^ b ^ c;
  endfunction

  function automatic logic [OW-1:0] csa_c(input logic [OW-1:0] a, b, c);
    return ((a & b) | (a & c) | (b & c)) << 1;
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) ops[i] = ops_flat[i*OW +: OW];
    cnt = N;
    for (int lv = 0; lv < N; lv++) begin
      for (int i = 0; i < N; i++) nxt[i] = '0;
      ncnt = 0;
      if (cnt > 2) begin
        for (int g = 0; g < N; g += 3) begin
          if (g + 2 < cnt) begin
            nxt[ncnt]   = csa_s(ops[g], ops[g+1], ops[g+2]);
            nxt[ncnt+1] = csa_c(ops[g], ops[g+1], ops[g+2]);
            ncnt += 2;
          end else if (g + 1 < cnt) begin
            nxt[ncnt]   = ops[g];
            nxt[ncnt+1] = ops[g+1];
            ncnt += 2;
          end else if (g < cnt) begin
            nxt[ncnt] = ops[g];
            ncnt += 1;
          end
        end
        for (int i = 0; i < N; i++) ops[i] = nxt[i];
        cnt = ncnt;
      end
    end
    sum = (cnt > 1) ? ops[0] + ops[1] : ops[0];
  end
endmodule

// File: rtl/fir16_par.sv
module fir16_par #(
  parameter int W    = 16,
  parameter int NTAP = 16,
  parameter logic [NTAP*W-1:0] COEFS = {NTAP{16'sd1}},
  localparam int GROW = $clog2(NTAP),
  localparam int OW   = 2*W + GROW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_sample,
  output logic          in_ready,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  logic load_ev, shift_ev;
  logic [NTAP*OW-1:0] prod_flat;
  logic [OW-1:0] ref_sum;

  fir16_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_ready(in_ready), .load_ev(load_ev), .shift_ev(shift_ev)
  );

  fir16_taps #(.W(W), .NTAP(NTAP), .OW(OW), .COEFS(COEFS)) u_taps (
    .clk(clk), .rst(rst), .load_ev(load_ev), .shift_ev(shift_ev),
    .in_sample(in_sample), .prod_flat(prod_flat)
  );

  fir16_csa_tree #(.N(NTAP), .OW(OW)) u_tree (
    .ops_flat(prod_flat), .sum(out_data)
  );

  assign out_valid = shift_ev;

  always_comb begin
    ref_sum = '0;
    for (int k = 0; k < NTAP; k++) ref_sum = ref_sum + prod_flat[k*OW +: OW];
  end

  // R4: compressor tree agrees with a plain chain of additions
  a_r4_tree_matches: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data == ref_sum);
  // R3: a strobe is always preceded by an accepted sample
  a_r3_strobe_follows_accept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));
  // R5: no acceptance during the strobe cycle
  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
endmodule

// File: tb/fir16_par_tb.sv
module fir16_par_tb;
  localparam int W = 16;
  localparam int N = 16;
  localparam int OW = 2*W + 4;
  localparam logic [N*W-1:0] COEF_A = {
    16'sd8, -16'sd19, 16'sd20000, -16'sd4000, 16'sd777, 16'sd0, -16'sd1, 16'sd5,
    16'h8000, 16'sd32767, 16'sd1024, -16'sd250, 16'sd100, 16'sd12, -16'sd7, 16'sd3};
  localparam logic [N*W-1:0] COEF_M = {N{16'h8000}};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [W-1:0] in_sample = '0;
  logic rdy_a, ov_a, rdy_m, ov_m;
  logic [OW-1:0] y_a, y_m;
  int checks = 0, errors = 0;
  bit done = 0;
  longint hist [N];

  always #5 clk = ~clk;

  fir16_par #(.W(W), .NTAP(N), .COEFS(COEF_A)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(rdy_a), .out_valid(ov_a), .out_data(y_a));
  fir16_par #(.W(W), .NTAP(N), .COEFS(COEF_M)) u_dut_max (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(rdy_m), .out_valid(ov_m), .out_data(y_m));

  function automatic longint expect_y(input logic [N*W-1:0] cf);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'($signed(cf[k*W +: W])) * hist[k];
    return s;
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic send(input logic [W-1:0] x, input bit junk);
    @(negedge clk);
    chk("R2 ready before accept", longint'(rdy_a), 1);
    chk("R3 no strobe while waiting", longint'(ov_a), 0);
    in_valid = 1; in_sample = x;
    @(negedge clk);
    for (int k = N-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(x));
    chk("R3 strobe after accept", longint'(ov_a), 1);
    chk("R4 convolution", longint'($signed(y_a)), expect_y(COEF_A));
    chk("R7 full precision", longint'($signed(y_m)), expect_y(COEF_M));
    if (junk) begin
      in_sample = W'($urandom);
      @(negedge clk);
      chk("R5 busy offer gives no strobe", longint'(ov_a), 0);
    end
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    logic [OW-1:0] held;
    held = y_a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R6 idle no strobe", longint'(ov_a), 0);
      chk("R8 output held", longint'($signed(y_a)), longint'($signed(held)));
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe low", longint'(ov_a), 0);
    chk("R1 reset ready high", longint'(rdy_a), 1);
    chk("R1 reset output zero", longint'($signed(y_a)), 0);
    rst = 0;
    // impulse: reveals each coefficient at its tap position (R4)
    send(16'sd1, 0);
    for (int i = 0; i < N + 2; i++) send(16'sd0, 0);
    // step
    for (int i = 0; i < 20; i++) send(16'sd1000, 0);
    idle(4);
    // full-scale negative and positive runs (R7)
    for (int i = 0; i < N; i++) send(16'h8000, 0);
    chk("R7 extreme positive sum", longint'($signed(y_m)), longint'(1) << 34);
    for (int i = 0; i < N; i++) send(16'sd32767, 0);
    // busy-cycle offers must vanish (R5)
    for (int i = 0; i < 10; i++) send(W'($urandom), 1);
    // random stream with idle gaps (R6)
    for (int i = 0; i < 80; i++) begin
      send(W'($urandom), (i % 7) == 3);
      if ((i % 5) == 2) idle(1 + (i % 3));
    end
    // reset mid-stream clears history (R1)
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int k = 0; k < N; k++) hist[k] = 0;
    chk("R1 reset clears output", longint'($signed(y_a)), 0);
    send(16'sd2, 0);
    send(-16'sd3, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule